// File: doc/BRIEF.md
# External Bus Address-Latch and Code-Read Strobe Generator

This block generates the timing strobes for the multiplexed external bus of an 8-bit controller. The oscillator clock is divided into a machine cycle of twelve ticks: six states of two phases each. In every state the block drives the address-latch strobe (`ale`) and the active-low code-read strobe (`psen_n`). It also tells the pin logic what the low port carries in each tick: the address byte, the data or code byte, or nothing. For the high port it selects either the upper address byte or the port's own latch value.

The core announces the kind of the next machine cycle on `cyc_kind`, and the block samples it in the last tick of the current cycle. The kinds are a plain code fetch, an external data move and a code-table read. A data move takes two machine cycles, `XADDR` then `XXFER`. In `XXFER` the block drops one address-latch pulse and both code-read pulses, and asserts the data strobe `xstrb_n` in their place.

When `ale_off` is set, the address-latch output rests high except during data moves and table reads. The `ale_off` control has no effect while `ext_exec` indicates execution from external code memory.

The sequencer has four states:
- `ST_FETCH`: normal fetch.
- `ST_XADDR`: first cycle of a data move.
- `ST_XXFER`: second cycle of a data move.
- `ST_TABLE`: code-table read.

Transitions happen only on the last tick of a machine cycle:
- `XADDR` always goes to `XXFER`.
- Every other state follows the sampled kind: 1 goes to `XADDR`, 2 goes to `TABLE`, and 0 or 3 go to `FETCH`.

Top module: `xbus_strobe_gen`

## Requirements
- R1: While `rst` is high, `ale`=1, `psen_n`=1, `xstrb_n`=1 and `p0_sel`=0. After release the tick count restarts at 0, so the first `ale` pulse appears on tick 1.
- R2: In fetch, data-move-first and table cycles, `ale` is high for exactly one tick on ticks 1 and 7 (the second phase of states 1 and 4), which is two pulses per twelve clocks.
- R3: In a fetch cycle `psen_n` is low on ticks 2–5 and 8–11 when `ext_exec`=1. It stays high for the whole cycle when `ext_exec`=0.
- R4: A data move (`cyc_kind`=1) lasts two machine cycles. In the second cycle, `ale` has no tick-1 pulse (only tick 7), `psen_n` stays high for all 12 ticks, and `xstrb_n` is low on ticks 0–5. The `cyc_kind` value sampled at the end of the first cycle is ignored.
- R5: With `ale_off`=1 and `ext_exec`=0, `ale` is held at 1 for all ticks of a fetch cycle.
- R6: With `ale_off`=1, `ale` still pulses normally in both data-move cycles and in table cycles.
- R7: With `ext_exec`=1, `ale_off` has no effect on `ale`.
- R8: A table cycle (`cyc_kind`=2) drives `psen_n` low on ticks 2–5 and 8–11 even when `ext_exec`=0.
- R9: During both data-move cycles with `addr16`=0, `p2_sel_reg`=1 and `p2_out`=`p2_latch`. Otherwise `p2_sel_reg`=0 and `p2_out`=`addr_hi`.
- R10: `p0_sel` uses the codes 0 = float, 1 = address, 2 = data.
  - Ticks 0, 1, 6 and 7 give 1, except ticks 0 and 1 of the second data-move cycle, which give 2.
  - Ticks 2–5 give 2 when `psen_n` is low or in the second data-move cycle.
  - Ticks 8–11 give 2 when `psen_n` is low.
  - All other ticks give 0.
- R11: `cyc_kind` is sampled on the last tick (tick 11) of each machine cycle. Code 3 is treated as a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Asynchronous reset, active high |
| cyc_kind | input | 2 | Kind of next machine cycle: 0 fetch, 1 data move, 2 table read, 3 fetch |
| ext_exec | input | 1 | Code executes from external memory |
| ale_off | input | 1 | Address-latch suppression control |
| addr16 | input | 1 | Data move uses a 16-bit address |
| addr_hi | input | 8 | Upper address byte |
| p2_latch | input | 8 | High port latch value |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Code-read strobe, active low |
| xstrb_n | output | 1 | Data read/write strobe, active low |
| p0_sel | output | 2 | Low port content code |
| p2_sel_reg | output | 1 | High port shows the latch value |
| p2_out | output | 8 | High port value |

## Verification
The hardest situation to reach is the second cycle of a data move taken with the address-latch disabled and execution internal. This is where the R5 suppression and the R4/R6 exceptions meet.

Getting there requires `cyc_kind` to be valid exactly at tick 11 of the preceding cycle. The stimulus table therefore drives each row's cycle kind one machine cycle ahead, during tick 0 of the previous row. It changes `ext_exec`, `ale_off` and `addr16` only on tick 11.

Junk kinds are placed where they must be ignored: a table code in the row for a second data-move cycle, and code 3 in a fetch row.

// File: rtl/xbus_strobe_pkg.sv
package xbus_strobe_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_XDATA = 2'd1,
        KIND_TABLE = 2'd2,
        KIND_SPARE = 2'd3
    } cyc_kind_t;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_XADDR = 2'd1,
        ST_XXFER = 2'd2,
        ST_TABLE = 2'd3
    } bus_state_t;

    typedef enum logic [1:0] {
        P0_FLOAT = 2'd0,
        P0_ADDR  = 2'd1,
        P0_DATA  = 2'd2
    } p0_mode_t;

endpackage

// File: rtl/xbus_tick_ctr.sv
module xbus_tick_ctr #(
    parameter int STATES = 6,
    parameter int PHASES = 2,
    localparam int TICKS  = STATES * PHASES,
    localparam int TICK_W = $clog2(TICKS)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [TICK_W-1:0] tick,
    output logic              last
);

    localparam logic [TICK_W-1:0] TICK_MAX = TICK_W'(TICKS - 1);

    assign last = (tick == TICK_MAX);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            tick <= '0;
        end else if (last) begin
            tick <= '0;
        end else begin
            tick <= tick + TICK_W'(1);
        end
    end

endmodule

// File: rtl/xbus_cycle_fsm.sv
module xbus_cycle_fsm
    import xbus_strobe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       last,
    input  logic [1:0] cyc_kind,
    output bus_state_t state
);

    bus_state_t state_nx;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state <= ST_FETCH;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (last) begin
            unique case (state)
                ST_XADDR: state_nx = ST_XXFER;
                ST_FETCH,
                ST_XXFER,
                ST_TABLE: begin
                    unique case (cyc_kind_t'(cyc_kind))
                        KIND_XDATA: state_nx = ST_XADDR;
                        KIND_TABLE: state_nx = ST_TABLE;
                        KIND_FETCH,
                        KIND_SPARE: state_nx = ST_FETCH;
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec
    import xbus_strobe_pkg::*;
#(
    parameter int STATES = 6,
    parameter int PHASES = 2,
    parameter int DW     = 8,
    localparam int TICKS  = STATES * PHASES,
    localparam int TICK_W = $clog2(TICKS),
    localparam int HALF   = TICKS / 2
) (
    input  logic              rst,
    input  bus_state_t        state,
    input  logic [TICK_W-1:0] tick,
    input  logic              ext_exec,
    input  logic              ale_off,
    input  logic              addr16,
    input  logic [DW-1:0]     addr_hi,
    input  logic [DW-1:0]     p2_latch,
    output logic              ale,
    output logic              psen_n,
    output logic              xstrb_n,
    output logic [1:0]        p0_sel,
    output logic              p2_sel_reg,
    output logic [DW-1:0]     p2_out
);

    logic              second_half;
    logic [TICK_W-1:0] pos;
    logic              ale_slot;
    logic              addr_slot;
    logic              read_slot;
    logic              ale_raw;
    logic              psen_on;
    logic              bus_move;
    logic              xfer_win;
    logic              psen_act;
    p0_mode_t          p0_mode;

    assign second_half = (tick >= TICK_W'(HALF));
    assign pos         = second_half ? (tick - TICK_W'(HALF)) : tick;
    assign ale_slot    = (pos == TICK_W'(PHASES - 1));
    assign addr_slot   = (pos < TICK_W'(PHASES));
    assign read_slot   = !addr_slot;

    always_comb begin
        ale_raw  = 1'b0;
        psen_on  = 1'b0;
        bus_move = 1'b0;
        xfer_win = 1'b0;
        unique case (state)
            ST_FETCH: begin
                ale_raw = ale_slot;
                psen_on = ext_exec;
            end
            ST_XADDR: begin
                ale_raw  = ale_slot;
                psen_on  = ext_exec;
                bus_move = 1'b1;
            end
            ST_XXFER: begin
                ale_raw  = ale_slot && second_half;
                bus_move = 1'b1;
                xfer_win = !second_half;
            end
            ST_TABLE: begin
                ale_raw  = ale_slot;
                psen_on  = 1'b1;
                bus_move = 1'b1;
            end
        endcase
    end

    assign psen_act = psen_on && read_slot;

    always_comb begin
        if (xfer_win) begin
            p0_mode = P0_DATA;
        end else if (addr_slot) begin
            p0_mode = P0_ADDR;
        end else if (psen_act) begin
            p0_mode = P0_DATA;
        end else begin
            p0_mode = P0_FLOAT;
        end
    end

    always_comb begin
        if (rst) begin
            ale     = 1'b1;
            psen_n  = 1'b1;
            xstrb_n = 1'b1;
            p0_sel  = P0_FLOAT;
        end else begin
            ale     = (ale_off && !ext_exec && !bus_move) ? 1'b1 : ale_raw;
            psen_n  = !psen_act;
            xstrb_n = !xfer_win;
            p0_sel  = p0_mode;
        end
    end

    assign p2_sel_reg = ((state == ST_XADDR) || (state == ST_XXFER)) && !addr16;
    assign p2_out     = p2_sel_reg ? p2_latch : addr_hi;

endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_strobe_pkg::*;
#(
    parameter int STATES = 6,
    parameter int PHASES = 2,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cyc_kind,
    input  logic          ext_exec,
    input  logic          ale_off,
    input  logic          addr16,
    input  logic [DW-1:0] addr_hi,
    input  logic [DW-1:0] p2_latch,
    output logic          ale,
    output logic          psen_n,
    output logic          xstrb_n,
    output logic [1:0]    p0_sel,
    output logic          p2_sel_reg,
    output logic [DW-1:0] p2_out
);

    localparam int TICK_W = $clog2(STATES * PHASES);

    logic [TICK_W-1:0] tick;
    logic              last;
    bus_state_t        state;

    xbus_tick_ctr #(.STATES(STATES), .PHASES(PHASES)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .last (last)
    );

    xbus_cycle_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .last     (last),
        .cyc_kind (cyc_kind),
        .state    (state)
    );

    xbus_strobe_dec #(.STATES(STATES), .PHASES(PHASES), .DW(DW)) u_dec (
        .rst        (rst),
        .state      (state),
        .tick       (tick),
        .ext_exec   (ext_exec),
        .ale_off    (ale_off),
        .addr16     (addr16),
        .addr_hi    (addr_hi),
        .p2_latch   (p2_latch),
        .ale        (ale),
        .psen_n     (psen_n),
        .xstrb_n    (xstrb_n),
        .p0_sel     (p0_sel),
        .p2_sel_reg (p2_sel_reg),
        .p2_out     (p2_out)
    );

endmodule

// File: rtl/xbus_strobe_chk.sv
module xbus_strobe_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ale_off,
    input logic          addr16,
    input logic [DW-1:0] p2_latch,
    input logic          ale,
    input logic          psen_n,
    input logic          xstrb_n,
    input logic [1:0]    p0_sel,
    input logic          p2_sel_reg,
    input logic [DW-1:0] p2_out
);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |-> (ale && psen_n && xstrb_n && p0_sel == 2'd0));

    p_ale_one_tick_r2: assert property (@(posedge clk) disable iff (rst)
        ($rose(ale) && !ale_off) |=> !ale);

    p_no_ale_in_read_r3: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> !ale);

    p_strobes_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !xstrb_n |-> psen_n);

    p_strobe_min_width_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(xstrb_n) |=> !xstrb_n);

    p_high_port_reg_r9: assert property (@(posedge clk) disable iff (rst)
        (!xstrb_n && !addr16) |-> (p2_sel_reg && p2_out == p2_latch));

    p_data_code_valid_r10: assert property (@(posedge clk) disable iff (rst)
        (!xstrb_n || !psen_n) |-> (p0_sel == 2'd2));

endmodule

bind xbus_strobe_gen xbus_strobe_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ale_off    (ale_off),
    .addr16     (addr16),
    .p2_latch   (p2_latch),
    .ale        (ale),
    .psen_n     (psen_n),
    .xstrb_n    (xstrb_n),
    .p0_sel     (p0_sel),
    .p2_sel_reg (p2_sel_reg),
    .p2_out     (p2_out)
);

// File: tb/sim_xbus_strobe_gen.sv
module sim_xbus_strobe_gen;

    typedef struct packed {
        logic [1:0]  kind;
        logic        ext;
        logic        off;
        logic        a16;
        logic [11:0] ale_pat;
        logic [11:0] psen_pat;
        logic [11:0] strb_pat;
        logic [1:0]  p0_t1;
        logic [1:0]  p0_t3;
        logic        use_reg;
    } vec_t;

    localparam int NV = 13;
    localparam logic [7:0] AHI = 8'hA5;
    localparam logic [7:0] PLT = 8'h3C;

    // one row per machine cycle; bit j of a pattern is the value on tick j
    localparam vec_t TAB [NV] = '{
        '{2'd0, 1'b1, 1'b0, 1'b1, 12'h082, 12'h0C3, 12'hFFF, 2'd1, 2'd2, 1'b0}, // fetch, ext code
        '{2'd0, 1'b0, 1'b0, 1'b1, 12'h082, 12'hFFF, 12'hFFF, 2'd1, 2'd0, 1'b0}, // fetch, internal
        '{2'd0, 1'b0, 1'b1, 1'b1, 12'hFFF, 12'hFFF, 12'hFFF, 2'd1, 2'd0, 1'b0}, // R5 suppressed
        '{2'd1, 1'b0, 1'b1, 1'b1, 12'h082, 12'hFFF, 12'hFFF, 2'd1, 2'd0, 1'b0}, // R6 move 1st
        '{2'd2, 1'b0, 1'b1, 1'b1, 12'h080, 12'hFFF, 12'hFC0, 2'd2, 2'd2, 1'b0}, // R4 move 2nd, kind ignored
        '{2'd2, 1'b0, 1'b1, 1'b1, 12'h082, 12'h0C3, 12'hFFF, 2'd1, 2'd2, 1'b0}, // R8 table
        '{2'd0, 1'b1, 1'b1, 1'b1, 12'h082, 12'h0C3, 12'hFFF, 2'd1, 2'd2, 1'b0}, // R7
        '{2'd1, 1'b1, 1'b0, 1'b0, 12'h082, 12'h0C3, 12'hFFF, 2'd1, 2'd2, 1'b1}, // R9 8-bit move
        '{2'd0, 1'b1, 1'b0, 1'b0, 12'h080, 12'hFFF, 12'hFC0, 2'd2, 2'd2, 1'b1}, // R4 R9
        '{2'd3, 1'b1, 1'b0, 1'b0, 12'h082, 12'h0C3, 12'hFFF, 2'd1, 2'd2, 1'b0}, // R11 code 3
        '{2'd1, 1'b1, 1'b1, 1'b1, 12'h082, 12'h0C3, 12'hFFF, 2'd1, 2'd2, 1'b0}, // move, ext
        '{2'd0, 1'b1, 1'b1, 1'b1, 12'h080, 12'hFFF, 12'hFC0, 2'd2, 2'd2, 1'b0},
        '{2'd0, 1'b0, 1'b0, 1'b1, 12'h082, 12'hFFF, 12'hFFF, 2'd1, 2'd0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cyc_kind = 2'd0;
    logic       ext_exec = 1'b0;
    logic       ale_off = 1'b0;
    logic       addr16 = 1'b1;
    logic [7:0] addr_hi = AHI;
    logic [7:0] p2_latch = PLT;
    logic       ale, psen_n, xstrb_n, p2_sel_reg;
    logic [1:0] p0_sel;
    logic [7:0] p2_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    xbus_strobe_gen u0 (
        .clk(clk), .rst(rst), .cyc_kind(cyc_kind), .ext_exec(ext_exec),
        .ale_off(ale_off), .addr16(addr16), .addr_hi(addr_hi),
        .p2_latch(p2_latch), .ale(ale), .psen_n(psen_n), .xstrb_n(xstrb_n),
        .p0_sel(p0_sel), .p2_sel_reg(p2_sel_reg), .p2_out(p2_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        logic [11:0] got_ale, got_psen, got_strb;
        logic [1:0]  got_p0a, got_p0b;
        logic [7:0]  got_p2;
        ext_exec = TAB[0].ext;
        ale_off  = TAB[0].off;
        addr16   = TAB[0].a16;
        repeat (3) @(negedge clk);
        #1;
        check("R1 ale in reset", 32'(ale), 32'd1);
        check("R1 psen_n in reset", 32'(psen_n), 32'd1);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            for (int j = 0; j < 12; j++) begin
                #1;
                got_ale[j]  = ale;
                got_psen[j] = psen_n;
                got_strb[j] = xstrb_n;
                if (j == 1) got_p0a = p0_sel;
                if (j == 3) begin
                    got_p0b = p0_sel;
                    got_p2  = p2_out;
                end
                if (j == 0) cyc_kind = (i + 1 < NV) ? TAB[i + 1].kind : 2'd0;
                if (j == 11 && i + 1 < NV) begin
                    ext_exec = TAB[i + 1].ext;
                    ale_off  = TAB[i + 1].off;
                    addr16   = TAB[i + 1].a16;
                end
                @(negedge clk);
            end
            check($sformatf("R2 R5 R6 R7 R11 ale row %0d", i), 32'(got_ale), 32'(TAB[i].ale_pat));
            check($sformatf("R3 R4 R8 psen_n row %0d", i), 32'(got_psen), 32'(TAB[i].psen_pat));
            check($sformatf("R4 R11 xstrb_n row %0d", i), 32'(got_strb), 32'(TAB[i].strb_pat));
            check($sformatf("R10 p0_sel tick1 row %0d", i), 32'(got_p0a), 32'(TAB[i].p0_t1));
            check($sformatf("R10 p0_sel tick3 row %0d", i), 32'(got_p0b), 32'(TAB[i].p0_t3));
            check($sformatf("R9 p2_out row %0d", i), 32'(got_p2),
                  32'(TAB[i].use_reg ? PLT : AHI));
        end
        // R1: mid-run reset, then restart of the tick count
        ext_exec = 1'b1;
        ale_off  = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        #1;
        check("R1 ale forced", 32'(ale), 32'd1);
        check("R1 psen_n forced", 32'(psen_n), 32'd1);
        check("R1 xstrb_n forced", 32'(xstrb_n), 32'd1);
        check("R1 p0_sel float", 32'(p0_sel), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 tick0 ale low", 32'(ale), 32'd0);
        @(negedge clk);
        #1;
        check("R1 tick1 ale pulse", 32'(ale), 32'd1);
        @(negedge clk);
        #1;
        check("R1 tick2 psen_n low", 32'(psen_n), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule